// File: doc/BRIEF.md
# I2C Target Receive Front End

This block is the bus-facing half of an I2C target. It samples the two raw bus lines on the system clock and passes each one through a glitch filter. From the filtered levels it finds START, repeated START and STOP conditions, and it keeps a bus-busy flag. After a START it shifts in the address byte. It compares the 7-bit address with a programmable own address, or recognises a general call when that is enabled. It then lets the host decide whether to acknowledge. Bytes written by the controller are handed to the host over a valid/ready interface. Both bus outputs are open-drain pull-down enables.

Whenever the host has not yet decided on an address or taken a byte, the block holds SCL low. The controller therefore waits, and nothing is lost. A START seen in any state sends the logic back to address reception. A STOP sends it back to idle. This means no malformed sequence and no filtered glitch can leave the target deaf to its own address.

Top module: `i2c_tgt_front`

## Requirements
- R1: A new level on either line is accepted only after FILT_N (default 2) consecutive system-clock samples agree, so a one-cycle low pulse on SDA changes nothing, and `bus_busy` stays 0.
- R2: `bus_busy` becomes 1 after a START (filtered SDA falls while filtered SCL is high) and 0 after a STOP (SDA rises while SCL is high), whatever address follows.
- R3: Address bits are sampled on rising SCL, most significant bit first. The eighth bit is the direction flag (1 = read). On a match the block raises `addr_req` with `addr_rw` at the falling SCL after the eighth bit, and holds SCL low until `dec_valid`.
- R4: With `dec_ack`=1 the block pulls SDA low in the ninth clock and releases it after the falling edge of SCL. With `dec_ack`=0 it never pulls SDA and ignores the rest of the transfer, so no byte reaches the host. SDA is never driven outside an acknowledge slot.
- R5: An address byte that matches neither the own address nor an enabled general call raises no `addr_req` and is not acknowledged.
- R6: Address byte 0x00 (address 0, write) raises `addr_req` with `addr_gc`=1 only while `gc_en`=1. With `gc_en`=0 it is never acknowledged.
- R7: Each written data byte is presented on `rx_data`, MSB first, with `rx_valid` after its eighth falling SCL edge. It is held, with SCL stretched, until `rx_ready`, and then acknowledged in the ninth clock.
- R8: A START in any state, including mid-address or mid-data byte, drops any pending request or byte, releases both lines and restarts address reception.
- R9: After reset and after a STOP both line enables are 0 and the logic is idle.
- R10: An SDA low pulse on an idle bus that passes the filter does not stop the block from acknowledging its own address afterwards.
- R11: After an acknowledged read address the block drives neither line until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Raw SCL level |
| sda_i | input | 1 | Raw SDA level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low (acknowledge) |
| own_addr | input | 7 | Own 7-bit target address |
| gc_en | input | 1 | Allow general call to be acknowledged |
| bus_busy | output | 1 | Between START and STOP |
| addr_req | output | 1 | Address matched, decision wanted |
| addr_rw | output | 1 | Direction flag of matched address |
| addr_gc | output | 1 | Matched address is a general call |
| dec_valid | input | 1 | Host decision strobe |
| dec_ack | input | 1 | Host decision: 1 acknowledge, 0 refuse |
| rx_data | output | 8 | Received data byte |
| rx_valid | output | 1 | Data byte available |
| rx_ready | input | 1 | Host takes the byte |

## Verification
A line change reaches the filtered level on the third clock edge after the change. The derived START, STOP or SCL edge acts on the next edge, so `bus_busy`, `addr_req` and `rx_valid` move about four cycles after the raw bus change. A stretch is released on the edge that samples `dec_valid` or `rx_ready`. The bench controller waits a quarter period of 8 cycles after every line change and observes the wired-AND bus level before moving on. All sampling is done on falling clock edges. Acknowledge and data results are therefore read well after they have settled, and bytes are compared with a queue of expected bytes when the host takes them.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W - 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DECIDE,
    ST_ACK,
    ST_DATA,
    ST_HOLD,
    ST_SKIP
  } tgt_state_e;

  // address field is all zero and direction is write
  function automatic logic is_gcall(logic [BYTE_W-1:0] b);
    return (b == '0);
  endfunction

  // does this address byte select us
  function automatic logic addr_accept(logic [BYTE_W-1:0] b,
                                       logic [ADDR_W-1:0] own,
                                       logic gc_on);
    if (b[BYTE_W-1:1] == '0) return gc_on && !b[0];
    return (b[BYTE_W-1:1] == own);
  endfunction

  function automatic logic start_cond(logic scl_now, logic scl_was,
                                      logic sda_now, logic sda_was);
    return scl_now && scl_was && sda_was && !sda_now;
  endfunction

  function automatic logic stop_cond(logic scl_now, logic scl_was,
                                     logic sda_now, logic sda_was);
    return scl_now && scl_was && !sda_was && sda_now;
  endfunction
endpackage

// File: rtl/i2c_tgt_filter.sv
module i2c_tgt_filter #(
  parameter int FILT_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic level
);
  logic [FILT_N-1:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist  <= '1;
      level <= 1'b1;
    end else begin
      hist <= {hist[FILT_N-2:0], raw};
      if (&hist)       level <= 1'b1;
      else if (~|hist) level <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond
  import i2c_tgt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_busy
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign start_ev = start_cond(scl_f, scl_p, sda_f, sda_p);
  assign stop_ev  = stop_cond(scl_f, scl_p, sda_f, sda_p);
  assign scl_rise = scl_f && !scl_p;
  assign scl_fall = !scl_f && scl_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bus_busy <= 1'b0;
    else if (start_ev) bus_busy <= 1'b1;
    else if (stop_ev)  bus_busy <= 1'b0;
  end
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_f,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_en,
  input  logic              dec_valid,
  input  logic              dec_ack,
  input  logic              rx_ready,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              addr_req,
  output logic              addr_rw,
  output logic              addr_gc,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              byte_full
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  tgt_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic              acked;

  assign byte_full = (cnt == CNT_W'(BYTE_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      sh       <= '0;
      acked    <= 1'b0;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
      addr_req <= 1'b0;
      addr_rw  <= 1'b0;
      addr_gc  <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else if (start_ev) begin
      state    <= ST_ADDR;
      cnt      <= '0;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
      addr_req <= 1'b0;
      rx_valid <= 1'b0;
    end else if (stop_ev) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
      addr_req <= 1'b0;
      rx_valid <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_DATA: begin
          if (scl_rise && !byte_full) begin
            sh  <= {sh[BYTE_W-2:0], sda_f};
            cnt <= cnt + CNT_W'(1);
          end else if (scl_fall && byte_full) begin
            cnt <= '0;
            if (state == ST_ADDR) begin
              if (addr_accept(sh, own_addr, gc_en)) begin
                addr_req <= 1'b1;
                addr_rw  <= sh[0];
                addr_gc  <= is_gcall(sh);
                scl_oe   <= 1'b1;
                state    <= ST_DECIDE;
              end else begin
                state <= ST_SKIP;
              end
            end else begin
              rx_data  <= sh;
              rx_valid <= 1'b1;
              scl_oe   <= 1'b1;
              state    <= ST_HOLD;
            end
          end
        end
        ST_DECIDE: begin
          if (dec_valid) begin
            addr_req <= 1'b0;
            sda_oe   <= dec_ack;
            acked    <= dec_ack;
            scl_oe   <= 1'b0;
            state    <= ST_ACK;
          end
        end
        ST_HOLD: begin
          if (rx_ready) begin
            rx_valid <= 1'b0;
            sda_oe   <= 1'b1;
            acked    <= 1'b1;
            scl_oe   <= 1'b0;
            state    <= ST_ACK;
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= (acked && !addr_rw) ? ST_DATA : ST_SKIP;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_tgt_front.sv
module i2c_tgt_front
  import i2c_tgt_pkg::*;
#(
  parameter int FILT_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_en,
  output logic              bus_busy,
  output logic              addr_req,
  output logic              addr_rw,
  output logic              addr_gc,
  input  logic              dec_valid,
  input  logic              dec_ack,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready
);
  localparam int NLINE = 2;

  logic [NLINE-1:0] raw_lines;
  logic [NLINE-1:0] filt_lines;
  logic scl_f, sda_f;
  logic start_ev, stop_ev, scl_rise, scl_fall, byte_full;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < NLINE; g++) begin : g_filt
    i2c_tgt_filter #(.FILT_N(FILT_N)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (raw_lines[g]),
      .level (filt_lines[g])
    );
  end

  assign scl_f = filt_lines[1];
  assign sda_f = filt_lines[0];

  i2c_tgt_cond u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .sda_f    (sda_f),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .bus_busy (bus_busy)
  );

  i2c_tgt_engine u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_f     (sda_f),
    .own_addr  (own_addr),
    .gc_en     (gc_en),
    .dec_valid (dec_valid),
    .dec_ack   (dec_ack),
    .rx_ready  (rx_ready),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .addr_req  (addr_req),
    .addr_rw   (addr_rw),
    .addr_gc   (addr_gc),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .byte_full (byte_full)
  );
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_ev,
  input logic       stop_ev,
  input logic       bus_busy,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       addr_req,
  input logic       addr_gc,
  input logic       gc_en,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data
);
  AST_BUSY_ON: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> bus_busy); // R2
  AST_BUSY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !bus_busy); // R2
  AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (!scl_oe && !sda_oe && !addr_req && !rx_valid)); // R8
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (!scl_oe && !sda_oe)); // R9
  AST_REQ_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    addr_req |-> scl_oe); // R3
  AST_RX_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> scl_oe); // R7
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !start_ev && !stop_ev) |=> (rx_valid && $stable(rx_data))); // R7
  AST_GC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(addr_req) && addr_gc) |-> $past(gc_en)); // R6
  AST_REQ_RX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_req && rx_valid)); // R3
endmodule

bind i2c_tgt_front i2c_tgt_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_ev (start_ev),
  .stop_ev  (stop_ev),
  .bus_busy (bus_busy),
  .scl_oe   (scl_oe),
  .sda_oe   (sda_oe),
  .addr_req (addr_req),
  .addr_gc  (addr_gc),
  .gc_en    (gc_en),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready),
  .rx_data  (rx_data)
);

// File: tb/i2c_tgt_front_test.sv
`timescale 1ns/1ps
module i2c_tgt_front_test;
  localparam int Q = 8;
  localparam int WD = 150000;
  localparam logic [6:0] OWN = 7'h2D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe, sda_oe, scl_i, sda_i;
  logic gc_en = 1'b0;
  logic bus_busy, addr_req, addr_rw, addr_gc, rx_valid;
  logic [7:0] rx_data;
  logic dec_valid = 1'b0, dec_ack = 1'b0, rx_ready = 1'b0;

  assign scl_i = m_scl & ~scl_oe;
  assign sda_i = m_sda & ~sda_oe;

  i2c_tgt_front uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN), .gc_en(gc_en),
    .bus_busy(bus_busy), .addr_req(addr_req), .addr_rw(addr_rw),
    .addr_gc(addr_gc), .dec_valid(dec_valid), .dec_ack(dec_ack),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int host_lat = 0, rx_lat = 0;
  bit host_ack = 1;
  int hcnt = 0, rcnt = 0, n_req = 0, n_rx = 0;
  bit got_rw = 0, got_gc = 0;
  int run = 0, maxrun = 0, bad_drive = 0;
  bit ack_win = 0, busy_seen = 0;
  logic [7:0] exp_q[$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // independent statement of which address bytes select the target
  function automatic bit want_req(logic [7:0] b, bit gce);
    if (b[7:1] == 7'd0) return gce && (b[0] == 1'b0);
    return b[7:1] == OWN;
  endfunction

  // host model: decision and byte acceptance, one clock at a time
  always @(negedge clk) begin
    if (dec_valid) dec_valid = 1'b0;
    else if (addr_req) begin
      if (hcnt >= host_lat) begin
        dec_valid = 1'b1; dec_ack = host_ack;
        got_rw = addr_rw; got_gc = addr_gc;
        n_req++; hcnt = 0;
      end else hcnt++;
    end else hcnt = 0;

    if (rx_ready) rx_ready = 1'b0;
    else if (rx_valid) begin
      if (rcnt >= rx_lat) begin
        rx_ready = 1'b1; n_rx++; rcnt = 0;
        if (exp_q.size() == 0) chk(0, "R7", "unexpected byte", rx_data, -1);
        else begin
          automatic logic [7:0] e = exp_q.pop_front();
          chk(rx_data == e, "R7", "received byte", rx_data, e);
        end
      end else rcnt++;
    end else rcnt = 0;
  end

  // per-clock bus monitor: SDA drive legality (R4), stretch length, busy
  always @(negedge clk) begin
    if (rst_n) begin
      if (m_scl && sda_oe && !ack_win) bad_drive++;
      if (scl_oe) begin run++; if (run > maxrun) maxrun = run; end
      else run = 0;
      if (bus_busy) busy_seen = 1;
    end
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic scl_up();
    m_scl = 1'b1; @(negedge clk);
    while (!scl_i) @(negedge clk);
    tick(Q);
  endtask
  task automatic bus_start();
    if (!m_scl) begin m_sda = 1'b1; tick(Q); scl_up(); end
    m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
  endtask
  task automatic bus_stop();
    m_sda = 1'b0; tick(Q); scl_up(); m_sda = 1'b1; tick(2*Q);
  endtask
  task automatic put_bit(bit b);
    m_sda = b; tick(Q); scl_up(); m_scl = 1'b0; tick(Q);
  endtask
  task automatic get_bit(output bit b);
    m_sda = 1'b1; tick(Q); scl_up(); b = sda_i; m_scl = 1'b0; tick(Q);
  endtask
  task automatic get_ack(output bit a);
    ack_win = 1; m_sda = 1'b1; tick(Q); scl_up(); a = !sda_i;
    m_scl = 1'b0; tick(Q); ack_win = 0;
  endtask
  task automatic send_byte(logic [7:0] v, output bit a);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_ack(a);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", WD, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit a, b;
    int reqs0, rx0, zeros;
    tick(3); rst_n = 1'b1; tick(3);
    chk({scl_oe, sda_oe, bus_busy, addr_req, rx_valid} == 5'b0, "R9", "reset outputs",
        {scl_oe, sda_oe, bus_busy, addr_req, rx_valid}, 0);

    // R1: single-cycle SDA pulse is filtered
    busy_seen = 0; m_sda = 1'b0; tick(1); m_sda = 1'b1; tick(12);
    chk(busy_seen == 0, "R1", "busy after 1-cycle pulse", busy_seen, 0);
    // R10: two-cycle pulse passes filter: START then STOP
    busy_seen = 0; m_sda = 1'b0; tick(2); m_sda = 1'b1; tick(12);
    chk(busy_seen == 1, "R2", "busy seen on filtered pulse", busy_seen, 1);
    chk(bus_busy == 0, "R2", "busy after pulse stop", bus_busy, 0);

    // write with stretching
    bus_start();
    chk(bus_busy == 1, "R2", "busy after START", bus_busy, 1);
    send_byte({OWN, 1'b0}, a);
    chk(a == 1, "R10", "own address acked after glitch", a, 1);
    chk(got_rw == 0, "R3", "direction flag write", got_rw, 0);
    exp_q.push_back(8'hA5); send_byte(8'hA5, a);
    chk(a == 1, "R7", "data ack", a, 1);
    host_lat = 20; rx_lat = 25; maxrun = 0;
    exp_q.push_back(8'h3C); send_byte(8'h3C, a);
    chk(a == 1, "R7", "data ack after wait", a, 1);
    chk(maxrun >= 25, "R7", "stretch length", maxrun, 25);
    bus_stop();
    chk(bus_busy == 0, "R2", "busy after STOP", bus_busy, 0);
    chk(!scl_oe && !sda_oe, "R9", "lines after STOP", {scl_oe, sda_oe}, 0);
    chk(n_rx == 2, "R7", "bytes received", n_rx, 2);
    host_lat = 0; rx_lat = 0;

    // R4: host refuses
    host_ack = 0; rx0 = n_rx;
    bus_start(); send_byte({OWN, 1'b0}, a);
    chk(a == 0, "R4", "refused address", a, 0);
    send_byte(8'h77, a);
    chk(a == 0, "R4", "byte after refusal", a, 0);
    bus_stop();
    chk(n_rx == rx0, "R4", "no byte after refusal", n_rx, rx0);
    host_ack = 1;

    // R5: other address
    reqs0 = n_req;
    bus_start(); send_byte(8'h44, a); bus_stop();
    chk(a == 0, "R5", "foreign address ack", a, 0);
    chk(n_req == reqs0 + int'(want_req(8'h44, 0)), "R5", "foreign request", n_req, reqs0);

    // R6: general call
    gc_en = 0; reqs0 = n_req;
    bus_start(); send_byte(8'h00, a); bus_stop();
    chk(a == 0, "R6", "gc disabled ack", a, 0);
    chk(n_req == reqs0, "R6", "gc disabled request", n_req, reqs0);
    gc_en = 1;
    bus_start(); send_byte(8'h00, a);
    chk(a == int'(want_req(8'h00, 1)), "R6", "gc enabled ack", a, 1);
    chk(got_gc == 1, "R6", "gc flag", got_gc, 1);
    exp_q.push_back(8'h99); send_byte(8'h99, a);
    chk(a == 1, "R6", "gc data ack", a, 1);
    bus_stop(); gc_en = 0;

    // R11: read address acked, then silent
    bus_start(); send_byte({OWN, 1'b1}, a);
    chk(a == 1, "R11", "read address ack", a, 1);
    chk(got_rw == 1, "R3", "direction flag read", got_rw, 1);
    zeros = 0;
    for (int i = 0; i < 8; i++) begin get_bit(b); if (!b) zeros++; end
    chk(zeros == 0, "R11", "SDA low during read", zeros, 0);
    put_bit(1'b1); bus_stop();

    // R8: repeated START mid data byte
    rx0 = n_rx;
    bus_start(); send_byte({OWN, 1'b0}, a);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_start(); send_byte({OWN, 1'b0}, a);
    chk(a == 1, "R8", "ack after restart mid-data", a, 1);
    exp_q.push_back(8'h81); send_byte(8'h81, a);
    bus_stop();
    chk(n_rx == rx0 + 1, "R8", "partial byte dropped", n_rx, rx0 + 1);

    // R8: repeated START mid address byte
    bus_start(); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_start(); send_byte({OWN, 1'b0}, a); bus_stop();
    chk(a == 1, "R8", "ack after restart mid-address", a, 1);

    chk(bad_drive == 0, "R4", "SDA driven outside ack slot", bad_drive, 0);
    chk(exp_q.size() == 0, "R7", "bytes left unreceived", exp_q.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule